// File: doc/BRIEF.md
# Prioritised Interrupt Request Arbiter with Chained Grant

The block sits between a processor and a row of device slots that share four interrupt request levels. Each slot raises a request on one of the four levels, and the levels are ORed onto four shared request lines. When idle, the processor side picks the most urgent level that is pending and that exceeds the processor's current 3-bit priority. It then drives the matching grant line. Lower levels, and levels at or below the priority, wait. They are not dropped.

A grant line enters slot 0, the slot nearest the processor, and passes from slot to slot. A slot that is requesting on that level keeps the grant, presents its vector and hides the grant from every slot behind it. Any other slot passes the grant on unchanged. The grant stays up until the processor acknowledges a presented vector. If no slot holds it for a configurable number of consecutive cycles, the grant is withdrawn and a one-cycle timeout flag is raised for the trap logic.

Top module: `irq_chain_arbiter`

## Requirements
- R1: While reset is low, `grant_o`, `dev_gnt_o`, `vec_valid_o` and `timeout_o` are all zero.
- R2: `bus_req_o[c]` is high, in the same cycle, exactly when some slot has its request high with level code c. Code c (0 to 3, from `dev_lvl_i[2i+1:2i]`) stands for urgency level 4+c.
- R3: At most one grant line is high. A grant on code c is only issued when 4+c is strictly greater than `cpu_pri_i`, so priority 7 blocks every level and priority 3 or lower admits every level. Among the pending admitted codes, the highest one is granted.
- R4: When the arbiter is idle and an admitted request is present at a clock edge, `grant_o` is one-hot on that level from that edge on.
- R5: The lowest-numbered slot that requests on the granted level takes the grant. Its `dev_gnt_o` bit is high, `vec_valid_o` is high, `vec_o` carries its vector and `slot_o` carries its index.
- R6: A slot that is not requesting, or that requests on a different level, passes the grant through to the next slot.
- R7: An edge with `vec_valid_o` and `vec_ack_i` both high clears `grant_o`. No new grant is issued in the cycle that follows.
- R8: A request that is not admitted stays pending and is granted once the priority falls below its level.
- R9: After TIMEOUT_CYC consecutive edges in which a grant is held and no slot takes it, the grant is removed and `timeout_o` is high for exactly one cycle.
- R10: `vec_ack_i` has no effect while `vec_valid_o` is low. A slot that takes the grant at the edge where the count would expire prevents the timeout.
- R11: While a grant is held, neither a more urgent request nor a change of `cpu_pri_i` changes or preempts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_pri_i | input | 3 | Current processor priority |
| dev_req_i | input | NUM_SLOTS | Request from each slot, slot 0 nearest the processor |
| dev_lvl_i | input | 2*NUM_SLOTS | Level code of each slot's request |
| dev_vec_i | input | VEC_W*NUM_SLOTS | Vector of each slot |
| vec_ack_i | input | 1 | Processor accepts the presented vector |
| bus_req_o | output | 4 | Shared request line per level code |
| grant_o | output | 4 | Grant line driven by the processor side |
| dev_gnt_o | output | NUM_SLOTS | Slot that holds the grant |
| vec_valid_o | output | 1 | A slot is presenting its vector |
| vec_o | output | VEC_W | Presented vector |
| slot_o | output | SLOT_W | Index of the presenting slot |
| timeout_o | output | 1 | One-cycle pulse on an unanswered grant |

## Verification
The two functions that can meet in one cycle are the slot answering and the expiry of the unanswered-grant count. To provoke this, a slot requests, receives the grant and then withdraws its request. It re-raises the request exactly at the edge where the count reaches its limit. The slot must win: the grant stays, the vector is presented and no timeout pulse appears. A neighbouring case is also driven. An acknowledge arrives while a more urgent request and a raised priority are waiting. The bench judges that the held grant ends cleanly and that the new grant appears only one cycle later.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NUM_LVL  = 4;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned LVL_BASE = 4;
  localparam int unsigned PRI_W    = 3;

  typedef logic [NUM_LVL-1:0] lvl_mask_t;
  typedef enum logic {ST_IDLE, ST_WAIT} arb_state_e;
endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]       dev_req_i,
  input  logic [NUM_SLOTS*LVL_W-1:0] dev_lvl_i,
  input  logic [PRI_W-1:0]           cpu_pri_i,
  output lvl_mask_t                  bus_req_o,
  output logic                       pick_valid_o,
  output lvl_mask_t                  pick_mask_o
);
  lvl_mask_t admit, cand;

  always_comb begin
    bus_req_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (dev_req_i[i]) bus_req_o[dev_lvl_i[i*LVL_W +: LVL_W]] = 1'b1;
    end
  end

  // strict compare against the current priority
  always_comb begin
    for (int c = 0; c < NUM_LVL; c++) begin
      admit[c] = (4'(c + LVL_BASE) > {1'b0, cpu_pri_i});
    end
  end

  assign cand = bus_req_o & admit;

  // highest admitted level wins
  always_comb begin
    pick_mask_o = '0;
    for (int c = 0; c < NUM_LVL; c++) begin
      if (cand[c]) pick_mask_o = lvl_mask_t'(1) << c;
    end
  end

  assign pick_valid_o = |cand;
endmodule

// File: rtl/irq_chain_slot.sv
module irq_chain_slot
  import irq_arb_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  lvl_mask_t        gnt_i,
  input  logic             req_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0] vec_i,
  output lvl_mask_t        gnt_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  lvl_mask_t own;

  assign own    = req_i ? (lvl_mask_t'(1) << lvl_i) : '0;
  assign take_o = |(gnt_i & own);
  assign gnt_o  = gnt_i & ~own;
  assign vec_o  = take_o ? vec_i : '0;
endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
  import irq_arb_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pick_valid_i,
  input  lvl_mask_t pick_mask_i,
  input  logic      answer_i,
  input  logic      ack_i,
  output lvl_mask_t grant_o,
  output logic      timeout_o
);
  localparam int unsigned CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  arb_state_e       state_q;
  lvl_mask_t        grant_q;
  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      cnt_q   <= '0;
      to_q    <= 1'b0;
    end else begin
      to_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (pick_valid_i) begin
            grant_q <= pick_mask_i;
            cnt_q   <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (answer_i && ack_i) begin
            grant_q <= '0;
            state_q <= ST_IDLE;
          end else if (answer_i) begin
            cnt_q <= '0;
          end else if (cnt_q == CNT_LAST) begin
            grant_q <= '0;
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grant_o   = grant_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned TIMEOUT_CYC = 16,
  localparam int unsigned SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 cpu_pri_i,
  input  logic [NUM_SLOTS-1:0]       dev_req_i,
  input  logic [2*NUM_SLOTS-1:0]     dev_lvl_i,
  input  logic [VEC_W*NUM_SLOTS-1:0] dev_vec_i,
  input  logic                       vec_ack_i,
  output logic [3:0]                 bus_req_o,
  output logic [3:0]                 grant_o,
  output logic [NUM_SLOTS-1:0]       dev_gnt_o,
  output logic                       vec_valid_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic [SLOT_W-1:0]          slot_o,
  output logic                       timeout_o
);
  lvl_mask_t        pick_mask, grant, bus_req;
  logic             pick_valid, answer;
  lvl_mask_t        chain_w [NUM_SLOTS+1];
  logic [VEC_W-1:0] vec_w   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] take;

  irq_level_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .dev_req_i   (dev_req_i),
    .dev_lvl_i   (dev_lvl_i),
    .cpu_pri_i   (cpu_pri_i),
    .bus_req_o   (bus_req),
    .pick_valid_o(pick_valid),
    .pick_mask_o (pick_mask)
  );

  assign chain_w[0] = grant;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    irq_chain_slot #(.VEC_W(VEC_W)) u_slot (
      .gnt_i (chain_w[i]),
      .req_i (dev_req_i[i]),
      .lvl_i (dev_lvl_i[i*LVL_W +: LVL_W]),
      .vec_i (dev_vec_i[i*VEC_W +: VEC_W]),
      .gnt_o (chain_w[i+1]),
      .take_o(take[i]),
      .vec_o (vec_w[i])
    );
  end

  // grant absorbed somewhere along the chain
  assign answer = |(grant & ~chain_w[NUM_SLOTS]);

  irq_grant_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pick_valid_i(pick_valid),
    .pick_mask_i (pick_mask),
    .answer_i    (answer),
    .ack_i       (vec_ack_i),
    .grant_o     (grant),
    .timeout_o   (timeout_o)
  );

  always_comb begin
    vec_o  = '0;
    slot_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      vec_o = vec_o | vec_w[i];
      if (take[i]) slot_o = SLOT_W'(i);
    end
  end

  assign bus_req_o   = bus_req;
  assign grant_o     = grant;
  assign dev_gnt_o   = take;
  assign vec_valid_o = answer;
endmodule

// File: rtl/irq_chain_arbiter_chk.sv
module irq_chain_arbiter_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           cpu_pri_i,
  input logic                 vec_ack_i,
  input logic [3:0]           grant_o,
  input logic [NUM_SLOTS-1:0] dev_gnt_o,
  input logic                 vec_valid_o,
  input logic                 timeout_o
);
  logic [1:0] gidx;
  always_comb begin
    gidx = '0;
    for (int c = 0; c < 4; c++) if (grant_o[c]) gidx = 2'(c);
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R3
  AST_GRANT_ADMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|grant_o) |-> ({1'b1, gidx} > $past(cpu_pri_i))); // R3
  AST_SLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_gnt_o)); // R5
  AST_VALID_HAS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (|grant_o && $onehot(dev_gnt_o))); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_ack_i) |=> (grant_o == '0)); // R7
  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o && !(vec_valid_o && vec_ack_i)) |=> ((grant_o == $past(grant_o)) || timeout_o)); // R11
  AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (grant_o == '0)); // R9
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R9
endmodule

bind irq_chain_arbiter irq_chain_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/irq_chain_arbiter_bench.sv
`timescale 1ns/1ps
module irq_chain_arbiter_bench;
  localparam int NS = 4;
  localparam int VW = 8;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]      pri = 3'd7;
  logic [NS-1:0]   req = '0;
  logic [2*NS-1:0] lvl = '0;
  logic [VW*NS-1:0] vec = '0;
  logic ack = 1'b0;
  logic [3:0] bus_req, grant;
  logic [NS-1:0] dev_gnt;
  logic vvalid, tout;
  logic [VW-1:0] vout;
  logic [1:0] slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_chain_arbiter #(.NUM_SLOTS(NS), .VEC_W(VW), .TIMEOUT_CYC(TO)) u_irq_chain_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .cpu_pri_i(pri), .dev_req_i(req), .dev_lvl_i(lvl),
    .dev_vec_i(vec), .vec_ack_i(ack), .bus_req_o(bus_req), .grant_o(grant),
    .dev_gnt_o(dev_gnt), .vec_valid_o(vvalid), .vec_o(vout), .slot_o(slot),
    .timeout_o(tout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setdev(input int i, input bit r, input int l);
    req[i] = r;
    lvl[2*i +: 2] = 2'(l);
  endtask

  function automatic logic [3:0] exp_bus(input logic [NS-1:0] r, input logic [2*NS-1:0] l);
    logic [3:0] b = '0;
    for (int i = 0; i < NS; i++) if (r[i]) b[l[2*i +: 2]] = 1'b1;
    return b;
  endfunction

  function automatic void model(input logic [NS-1:0] r, input logic [2*NS-1:0] l,
                                input logic [2:0] p, output bit f, output int c, output int s);
    f = 0; c = 0; s = 0;
    for (int k = 3; k >= 0; k--) begin
      if (!f && (k + 4) > int'(p)) begin
        for (int i = NS - 1; i >= 0; i--) begin
          if (r[i] && int'(l[2*i +: 2]) == k) begin
            f = 1; c = k; s = i;
          end
        end
      end
    end
  endfunction

  task automatic serve(input string tag);
    ack = 1'b1;
    step();
    ack = 1'b0;
    check({tag, " R7 grant released"}, 32'(grant), 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) vec[i*VW +: VW] = VW'(8'hA0 + i);
    repeat (3) @(negedge clk);
    check("R1 grant in reset", 32'(grant), 0);
    check("R1 timeout in reset", 32'(tout), 0);
    check("R1 valid in reset", 32'(vvalid), 0);
    check("R1 dev_gnt in reset", 32'(dev_gnt), 0);
    rst_n = 1'b1;
    step();

    // blocked by priority, then admitted
    setdev(1, 1, 2); setdev(3, 1, 0); pri = 3'd7;
    #1 check("R2 bus lines", 32'(bus_req), 32'b0101);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R3 priority 7 blocks", 32'(grant), 0);
    end
    pri = 3'd5;
    step();
    check("R4 grant level 6", 32'(grant), 32'b0100);
    check("R5 slot index", 32'(slot), 1);
    check("R5 dev_gnt", 32'(dev_gnt), 32'b0010);
    check("R5 vector", 32'(vout), 32'hA1);
    serve("d1");
    setdev(1, 0, 0);
    step();
    check("R3 level 4 at pri 5", 32'(grant), 0);
    pri = 3'd4;
    step();
    check("R3 strict at pri 4", 32'(grant), 0);
    pri = 3'd3;
    step();
    check("R8 deferred request served", 32'(grant), 32'b0001);
    check("R8 slot", 32'(slot), 3);
    serve("d2");
    setdev(3, 0, 0);

    // chain pass-through
    setdev(0, 1, 1); setdev(2, 1, 3); setdev(3, 1, 3); pri = 3'd0;
    step();
    check("R3 highest level", 32'(grant), 32'b1000);
    check("R6 slot0 passes other level", 32'(slot), 2);
    check("R5 nearest taker vector", 32'(vout), 32'hA2);
    serve("d3");
    setdev(2, 0, 0);
    step();
    check("R6 idle slot passes", 32'(slot), 3);
    serve("d4");
    setdev(3, 0, 0);
    step();
    check("R5 level 5 grant", 32'(grant), 32'b0010);
    // no preemption
    setdev(1, 1, 3); pri = 3'd6;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R11 grant held", 32'(grant), 32'b0010);
    end
    serve("d5");
    setdev(0, 0, 0);
    step();
    check("R11 waiting level then granted", 32'(grant), 32'b1000);
    check("R11 slot", 32'(slot), 1);
    serve("d6");
    setdev(1, 0, 0);

    // timeout
    pri = 3'd0;
    setdev(2, 1, 2);
    step();
    check("R9 grant before withdraw", 32'(grant), 32'b0100);
    setdev(2, 0, 2);
    for (int k = 0; k < TO - 1; k++) begin
      ack = (k == 1);
      step();
      check("R10 grant kept, ack ignored", 32'(grant), 32'b0100);
      check("R9 no early timeout", 32'(tout), 0);
    end
    ack = 1'b0;
    step();
    check("R9 grant removed", 32'(grant), 0);
    check("R9 timeout pulse", 32'(tout), 1);
    step();
    check("R9 pulse one cycle", 32'(tout), 0);

    // answer at the expiry edge
    setdev(2, 1, 2);
    step();
    setdev(2, 0, 2);
    for (int k = 0; k < TO - 1; k++) step();
    setdev(2, 1, 2);
    #1 check("R10 late answer valid", 32'(vvalid), 1);
    step();
    check("R10 answer beats timeout", 32'(tout), 0);
    check("R10 grant stays", 32'(grant), 32'b0100);
    serve("d7");
    setdev(2, 0, 0);

    // random
    for (int it = 0; it < 400; it++) begin
      bit f; int c; int s;
      req = NS'($urandom);
      lvl = (2*NS)'($urandom);
      vec = (VW*NS)'($urandom);
      pri = 3'($urandom);
      #1 check("R2 random bus lines", 32'(bus_req), 32'(exp_bus(req, lvl)));
      model(req, lvl, pri, f, c, s);
      step();
      if (f) begin
        check("R3 random grant", 32'(grant), 32'(4'b0001 << c));
        check("R5 random slot", 32'(slot), 32'(s));
        check("R5 random vector", 32'(vout), 32'(vec[s*VW +: VW]));
        serve("rnd");
        req[s] = 1'b0;
      end else begin
        check("R3 random no grant", 32'(grant), 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule